// File: doc/BRIEF.md
# Dual-Bank Interleaved Scratchpad

A local word memory split into an even bank and an odd bank, each holding half of the words. Two independent read channels can each present an address per cycle. When the two addresses fall in different banks, both reads are accepted in the same cycle and both words come back one cycle later. This is the common case for a consumer that walks pairs of neighbouring words, such as the two operands of a multiply-accumulate step. A single write port stores one word per cycle and is always accepted.

Each read channel has a request side and a response side, and each side carries its own valid/ready handshake. A response stays on its port until the consumer takes it. While it waits, that port accepts no new request. When both requests hit the same bank, a small two-state arbiter serializes them. In state `ARB_PORT0_FIRST`, port 0 wins a clash and the arbiter moves to `ARB_PORT1_OWED`. In `ARB_PORT1_OWED`, port 1 wins any clash, and the arbiter returns to `ARB_PORT0_FIRST` on the following cycle whatever happens. Because of this, neither port can be starved. Each port has at most one read in flight, so its responses always come back in the order of its requests.

Top module: `dual_bank_spm`

## Requirements
- R1: After reset, both response valids are low and both request readies are high.
- R2: Address bit 0 selects the bank (0 even, 1 odd) and the remaining upper bits select the row, so a read of address A returns the word last written to A.
- R3: A request accepted at a clock edge presents its response valid, with its data, directly after the next edge.
- R4: Two requests in different banks, with both response slots free, are both accepted in the same cycle.
- R5: Two requests in the same bank are never both accepted in one cycle. From the idle arbiter state, port 0 wins the clash and port 1 is accepted on the next cycle.
- R6: A response whose ready is low keeps its valid and data unchanged, and its port's request ready stays low. The port is ready again in the same cycle that the response ready rises.
- R7: A read and a write to the same address in the same cycle return the word held before the write.
- R8: Under continuous same-bank requests on both ports, the winner alternates every cycle, starting with port 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | AW | Write word address |
| wr_data | input | DW | Write word |
| rq0_valid | input | 1 | Port 0 read request valid |
| rq0_ready | output | 1 | Port 0 read request accepted |
| rq0_addr | input | AW | Port 0 read address |
| rs0_valid | output | 1 | Port 0 response valid |
| rs0_ready | input | 1 | Port 0 response taken |
| rs0_data | output | DW | Port 0 response word |
| rq1_valid | input | 1 | Port 1 read request valid |
| rq1_ready | output | 1 | Port 1 read request accepted |
| rq1_addr | input | AW | Port 1 read address |
| rs1_valid | output | 1 | Port 1 response valid |
| rs1_ready | input | 1 | Port 1 response taken |
| rs1_data | output | DW | Port 1 response word |

## Verification
The bench fills a 16-word configuration with a value derived arithmetically from each address. It then applies every one of the 256 ordered address pairs to the two ports at once. Pairs split across banks must both be accepted together, and pairs in the same bank must serialize with port 0 first, so this sweep separates bank decoding from row decoding and parallel issue from serialized issue. A streaming run of same-bank requests on both ports checks that the winner alternates. A held response, with the other port reading the same bank underneath it, shows whether the stalled data is really latched. A read and a write to the same address in one cycle shows whether the read returns the old word or the new one.

// File: rtl/spm_pkg.sv
package spm_pkg;
    typedef enum logic {
        ARB_PORT0_FIRST = 1'b0,
        ARB_PORT1_OWED  = 1'b1
    } spm_arb_e;

    localparam int NPORT = 2;
endpackage

// File: rtl/spm_bank.sv
module spm_bank #(
    parameter int DW   = 32,
    parameter int ROWS = 512,
    parameter int RW   = 9
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [RW-1:0] wr_row,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    input  logic [RW-1:0] rd_row,
    output logic [DW-1:0] rd_q
);
    logic [DW-1:0] mem [ROWS];

    // read samples the array before this edge's write lands
    always_ff @(posedge clk) begin
        if (rd_en)
            rd_q <= mem[rd_row];
        if (wr_en)
            mem[wr_row] <= wr_data;
    end
endmodule

// File: rtl/spm_arbiter.sv
module spm_arbiter
    import spm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] want,
    input  logic       same_bank,
    output logic [1:0] lose
);
    spm_arb_e state_q, state_d;
    logic     clash;

    assign clash = want[0] && want[1] && same_bank;

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ARB_PORT0_FIRST;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        lose    = 2'b00;
        unique case (state_q)
            ARB_PORT0_FIRST: begin
                lose[1] = clash;
                if (clash)
                    state_d = ARB_PORT1_OWED;
            end
            ARB_PORT1_OWED: begin
                lose[0] = clash;
                state_d = ARB_PORT0_FIRST;
            end
            default: state_d = ARB_PORT0_FIRST;
        endcase
    end
endmodule

// File: rtl/spm_resp.sv
module spm_resp #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          gnt,
    input  logic          bank_sel,
    input  logic          rs_ready,
    input  logic [DW-1:0] q0,
    input  logic [DW-1:0] q1,
    output logic          rs_valid,
    output logic [DW-1:0] rs_data,
    output logic          can
);
    logic          fresh_q;
    logic          sel_q;
    logic [DW-1:0] hold_q;

    assign can     = !rs_valid || rs_ready;
    assign rs_data = fresh_q ? (sel_q ? q1 : q0) : hold_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rs_valid <= 1'b0;
            fresh_q  <= 1'b0;
            sel_q    <= 1'b0;
            hold_q   <= '0;
        end else begin
            fresh_q <= gnt;
            hold_q  <= rs_data;
            if (gnt) begin
                rs_valid <= 1'b1;
                sel_q    <= bank_sel;
            end else if (rs_ready) begin
                rs_valid <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/dual_bank_spm.sv
module dual_bank_spm
    import spm_pkg::*;
#(
    parameter  int DW    = 32,
    parameter  int DEPTH = 1024,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          rq0_valid,
    output logic          rq0_ready,
    input  logic [AW-1:0] rq0_addr,
    output logic          rs0_valid,
    input  logic          rs0_ready,
    output logic [DW-1:0] rs0_data,
    input  logic          rq1_valid,
    output logic          rq1_ready,
    input  logic [AW-1:0] rq1_addr,
    output logic          rs1_valid,
    input  logic          rs1_ready,
    output logic [DW-1:0] rs1_data
);
    localparam int RW   = AW - 1;
    localparam int ROWS = (DEPTH + 1) / 2;

    logic [NPORT-1:0] rq_v, rs_rdy, rs_v, can, want, lose, gnt;
    logic [AW-1:0]    rq_a   [NPORT];
    logic [DW-1:0]    rs_d   [NPORT];
    logic [DW-1:0]    bank_q [2];

    assign rq_v    = {rq1_valid, rq0_valid};
    assign rs_rdy  = {rs1_ready, rs0_ready};
    assign rq_a[0] = rq0_addr;
    assign rq_a[1] = rq1_addr;

    assign want = rq_v & can;
    assign gnt  = want & ~lose;

    assign rq0_ready = can[0] && !lose[0];
    assign rq1_ready = can[1] && !lose[1];
    assign rs0_valid = rs_v[0];
    assign rs1_valid = rs_v[1];
    assign rs0_data  = rs_d[0];
    assign rs1_data  = rs_d[1];

    spm_arbiter u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .want      (want),
        .same_bank (rq_a[0][0] == rq_a[1][0]),
        .lose      (lose)
    );

    for (genvar b = 0; b < 2; b++) begin : g_bank
        logic          from0;
        logic          rd_en;
        logic [RW-1:0] rd_row;

        assign from0  = gnt[0] && (rq_a[0][0] == 1'(b));
        assign rd_en  = from0 || (gnt[1] && (rq_a[1][0] == 1'(b)));
        assign rd_row = from0 ? rq_a[0][AW-1:1] : rq_a[1][AW-1:1];

        spm_bank #(.DW(DW), .ROWS(ROWS), .RW(RW)) u_bank (
            .clk     (clk),
            .wr_en   (wr_en && (wr_addr[0] == 1'(b))),
            .wr_row  (wr_addr[AW-1:1]),
            .wr_data (wr_data),
            .rd_en   (rd_en),
            .rd_row  (rd_row),
            .rd_q    (bank_q[b])
        );
    end

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        spm_resp #(.DW(DW)) u_resp (
            .clk      (clk),
            .rst_n    (rst_n),
            .gnt      (gnt[p]),
            .bank_sel (rq_a[p][0]),
            .rs_ready (rs_rdy[p]),
            .q0       (bank_q[0]),
            .q1       (bank_q[1]),
            .rs_valid (rs_v[p]),
            .rs_data  (rs_d[p]),
            .can      (can[p])
        );
    end
endmodule

// File: rtl/spm_checker.sv
module spm_checker #(
    parameter int AW = 10,
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rq0_valid,
    input logic          rq0_ready,
    input logic [AW-1:0] rq0_addr,
    input logic          rs0_valid,
    input logic          rs0_ready,
    input logic [DW-1:0] rs0_data,
    input logic          rq1_valid,
    input logic          rq1_ready,
    input logic [AW-1:0] rq1_addr,
    input logic          rs1_valid,
    input logic          rs1_ready,
    input logic [DW-1:0] rs1_data
);
    logic same, free0, free1;
    assign same  = rq0_addr[0] == rq1_addr[0];
    assign free0 = !rs0_valid || rs0_ready;
    assign free1 = !rs1_valid || rs1_ready;

    assert_dual_issue_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rq0_valid && rq1_valid && !same && free0 && free1) |-> (rq0_ready && rq1_ready));

    assert_one_winner_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rq0_valid && rq1_valid && same) |-> !(rq0_ready && rq1_ready));

    assert_owed_next_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rq0_valid && rq1_valid && same && rq0_ready && !rq1_ready && free1)
        |=> (!rq1_valid || rq1_ready));

    assert_latency0_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rq0_valid && rq0_ready) |=> rs0_valid);

    assert_latency1_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rq1_valid && rq1_ready) |=> rs1_valid);

    assert_hold0_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rs0_valid && !rs0_ready) |=> (rs0_valid && $stable(rs0_data)));

    assert_hold1_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rs1_valid && !rs1_ready) |=> (rs1_valid && $stable(rs1_data)));

    assert_stall0_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rs0_valid && !rs0_ready) |-> !rq0_ready);

    assert_stall1_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rs1_valid && !rs1_ready) |-> !rq1_ready);
endmodule

bind dual_bank_spm spm_checker #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/dual_bank_spm_bench.sv
module dual_bank_spm_bench;
    localparam int DW = 32;
    localparam int DEPTH = 16;
    localparam int AW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic rq0_valid = 1'b0, rq1_valid = 1'b0;
    logic [AW-1:0] rq0_addr = '0, rq1_addr = '0;
    logic rs0_ready = 1'b1, rs1_ready = 1'b1;
    logic rq0_ready, rq1_ready, rs0_valid, rs1_valid;
    logic [DW-1:0] rs0_data, rs1_data;

    logic [DW-1:0] ref_mem [DEPTH];
    int nchk = 0;
    int nfail = 0;

    always #2 clk = ~clk;

    dual_bank_spm #(.DW(DW), .DEPTH(DEPTH)) u_dual_bank_spm (.*);

    task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    function automatic logic [DW-1:0] pat(input int a, input int g);
        return {8'(g), 8'(a), 16'(a * 977 + g * 31)};
    endfunction

    task automatic write_word(input int a, input logic [DW-1:0] v);
        wr_en = 1'b1; wr_addr = AW'(a); wr_data = v;
        tick();
        wr_en = 1'b0;
        ref_mem[a] = v;
    endtask

    // both ports request at once, checks acceptance pattern and data
    task automatic read_pair(input int a, input int b);
        logic r0, r1;
        rs0_ready = 1'b1; rs1_ready = 1'b1;
        rq0_valid = 1'b1; rq0_addr = AW'(a);
        rq1_valid = 1'b1; rq1_addr = AW'(b);
        #1;
        r0 = rq0_ready; r1 = rq1_ready;
        if ((a % 2) != (b % 2))
            chk(r0 && r1, "R4 both accepted", {30'd0, r1, r0}, 32'd3);
        else
            chk(r0 && !r1, "R5 port0 first", {30'd0, r1, r0}, 32'd1);
        tick();
        rq0_valid = 1'b0;
        chk(rs0_valid == 1'b1, "R3 port0 valid", 32'(rs0_valid), 32'd1);
        chk(rs0_data == ref_mem[a], "R2 port0 data", rs0_data, ref_mem[a]);
        if (r1) begin
            rq1_valid = 1'b0;
            chk(rs1_data == ref_mem[b], "R2 port1 data", rs1_data, ref_mem[b]);
        end else begin
            #1;
            chk(rq1_ready == 1'b1, "R5 port1 next", 32'(rq1_ready), 32'd1);
            tick();
            rq1_valid = 1'b0;
            chk(rs1_valid == 1'b1, "R3 port1 valid", 32'(rs1_valid), 32'd1);
            chk(rs1_data == ref_mem[b], "R2 port1 data", rs1_data, ref_mem[b]);
        end
    endtask

    initial begin
        #(4 * 200000);
        nfail++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        int a0, a1, win;
        logic [DW-1:0] old_v;
        repeat (3) tick();
        rst_n = 1'b1;
        #1;
        chk({rs1_valid, rs0_valid} == 2'b00, "R1 resp idle", 32'({rs1_valid, rs0_valid}), 32'd0);
        chk({rq1_ready, rq0_ready} == 2'b11, "R1 req ready", 32'({rq1_ready, rq0_ready}), 32'd3);
        tick();

        for (int a = 0; a < DEPTH; a++) write_word(a, pat(a, 1));
        for (int a = 0; a < DEPTH; a++)
            for (int b = 0; b < DEPTH; b++)
                read_pair(a, b);
        tick();

        // R8: both ports stream even addresses
        a0 = 0; a1 = 8;
        rq0_valid = 1'b1; rq1_valid = 1'b1;
        for (int k = 0; k < 8; k++) begin
            rq0_addr = AW'(a0); rq1_addr = AW'(a1);
            #1;
            chk({rq1_ready, rq0_ready} == ((k % 2 == 0) ? 2'b01 : 2'b10), "R8 alternate",
                32'({rq1_ready, rq0_ready}), (k % 2 == 0) ? 32'd1 : 32'd2);
            win = k % 2;
            tick();
            if (win == 0) begin
                chk(rs0_data == ref_mem[a0], "R8 port0 data", rs0_data, ref_mem[a0]);
                a0 = (a0 + 2) % DEPTH;
            end else begin
                chk(rs1_data == ref_mem[a1], "R8 port1 data", rs1_data, ref_mem[a1]);
                a1 = (a1 + 2) % DEPTH;
            end
        end
        rq0_valid = 1'b0; rq1_valid = 1'b0;
        tick();

        // R6: stalled port0 response, port1 churns the same bank
        rs0_ready = 1'b0;
        rq0_valid = 1'b1; rq0_addr = 4'd3;
        tick();
        rq0_addr = 4'd5;
        rq1_valid = 1'b1;
        for (int k = 0; k < 3; k++) begin
            rq1_addr = AW'(7 + 2 * k);
            #1;
            chk(rq0_ready == 1'b0, "R6 stall", 32'(rq0_ready), 32'd0);
            chk(rs0_valid && rs0_data == ref_mem[3], "R6 hold", rs0_data, ref_mem[3]);
            tick();
        end
        rq1_valid = 1'b0;
        chk(rs0_data == ref_mem[3], "R6 hold after", rs0_data, ref_mem[3]);
        rs0_ready = 1'b1;
        #1;
        chk(rq0_ready == 1'b1, "R6 release", 32'(rq0_ready), 32'd1);
        tick();
        rq0_valid = 1'b0;
        chk(rs0_data == ref_mem[5], "R6 next data", rs0_data, ref_mem[5]);
        tick();

        // R7: read and write the same address in one cycle
        old_v = ref_mem[6];
        rq0_valid = 1'b1; rq0_addr = 4'd6;
        wr_en = 1'b1; wr_addr = 4'd6; wr_data = pat(6, 9);
        tick();
        wr_en = 1'b0;
        ref_mem[6] = pat(6, 9);
        chk(rs0_data == old_v, "R7 old word", rs0_data, old_v);
        tick();
        rq0_valid = 1'b0;
        chk(rs0_data == ref_mem[6], "R7 new word", rs0_data, ref_mem[6]);
        tick();

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule